// File: doc/BRIEF.md
# Physical Register Operand Scoreboard

This block decides whether a renamed instruction can issue by looking up its source operands in two busy tables, one for the integer physical register file and one for the floating-point physical register file. When an instruction is presented, every operand that names a busy register gets a bit in a five-bit pending mask. The mask stays held in the block, and writeback wakeups clear bits as producers complete. Once the mask is empty, the instruction is ready to issue.

Rename marks a register busy through a set port for each file. Writeback clears it through a wakeup port for each file. A wakeup also clears every held pending bit that waits on the same register of the same file. Two dependency flags come out of the mask. The true-dependency flag covers any pending operand. The address-dependency flag covers only the operands used to form a memory address, which are the second source and the condition-code source. A memory instruction whose address operands are free is flagged as able to start address generation, even if its other operands are still pending.

Top module: `opnd_scoreboard`

## Requirements
- R1: After reset both busy tables are clear, no instruction is held, the pending mask is zero and `true_dep`, `addr_dep`, `issue_rdy`, `addr_rdy` and `held_valid` are low.
- R2: Operand type codes are 0 integer, 1 integer 64-bit, 2 FP, 3 FP half and 4 integer pair, and codes 5 to 7 mean no operand. Codes 0 and 1 look up the integer table, and codes 2 and 3 look up the FP table. For rs2, code 4 means no operand.
- R3: If rs1 has type 4 (integer pair), it checks both `rs1_idx` and `rs1p_idx` in the integer table. A busy first register sets mask bit 0, and a busy second register sets mask bit 1.
- R4: The condition-code source `cc_idx` is always checked in the integer table, and if it is busy it sets mask bit 3. A busy rs2 sets mask bit 2.
- R5: If `rd_type` is 3 (FP half) and `rd_idx` is busy in the FP table, mask bit 4 is set. For any other destination type, bit 4 stays clear.
- R6: `true_dep` is high when any mask bit is set. `addr_dep` is high only when bit 2 or bit 3 is set. `issue_rdy` is high when an instruction is held and the mask is zero.
- R7: A wakeup clears a held mask bit only if the bit waits on the same register index in the same file. Bits waiting on the other file are unaffected.
- R8: A wakeup that arrives in the same cycle as a check makes that register count as not busy for that check.
- R9: A set makes the register busy for checks from the next cycle on. A wakeup clears the busy bit. If a set and a wakeup hit the same index in the same cycle, the register ends up busy.
- R10: `addr_rdy` is high when the held instruction was presented with `chk_mem` high and `addr_dep` is low.
- R11: A new check replaces the held instruction and its whole mask. Results appear one cycle after `chk_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| int_set_en | input | 1 | Mark an integer register busy |
| int_set_idx | input | 6 | Integer register to mark |
| fp_set_en | input | 1 | Mark an FP register busy |
| fp_set_idx | input | 6 | FP register to mark |
| int_wake_en | input | 1 | Integer writeback wakeup |
| int_wake_idx | input | 6 | Integer register written back |
| fp_wake_en | input | 1 | FP writeback wakeup |
| fp_wake_idx | input | 6 | FP register written back |
| chk_valid | input | 1 | Present an instruction for checking |
| chk_mem | input | 1 | Presented instruction is a memory operation |
| rs1_type | input | 3 | First source type code |
| rs1_idx | input | 6 | First source physical register |
| rs1p_idx | input | 6 | Second register of an integer-pair first source |
| rs2_type | input | 3 | Second source type code |
| rs2_idx | input | 6 | Second source physical register |
| cc_idx | input | 6 | Condition-code physical register (integer file) |
| rd_type | input | 3 | Destination type code |
| rd_idx | input | 6 | Destination physical register |
| held_valid | output | 1 | An instruction is held |
| pend | output | 5 | Pending mask: bit4 rd, bit3 cc, bit2 rs2, bit1 rs1 pair, bit0 rs1 |
| true_dep | output | 1 | Some operand is pending |
| addr_dep | output | 1 | An address operand is pending |
| issue_rdy | output | 1 | Held instruction has nothing pending |
| addr_rdy | output | 1 | Held memory instruction may form its address |

## Verification
A busy bit that is stuck set or stuck clear does not show up by itself. It shows as a wrong pending bit on the first check that names that register, one cycle after `chk_valid`. A held mask entry that stores the wrong index or the wrong file shows one cycle after a wakeup: the wrong bit clears, or no bit clears, and so `issue_rdy` or `addr_rdy` stays low when it should rise, or rises too early. The bench therefore marks registers busy and wakes them one at a time, and it compares the whole mask and all flags after every step.

// File: rtl/opnd_scoreboard.sv
module opnd_scoreboard #(
  parameter int NREG = 64,
  localparam int IW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          int_set_en,
  input  logic [IW-1:0] int_set_idx,
  input  logic          fp_set_en,
  input  logic [IW-1:0] fp_set_idx,
  input  logic          int_wake_en,
  input  logic [IW-1:0] int_wake_idx,
  input  logic          fp_wake_en,
  input  logic [IW-1:0] fp_wake_idx,
  input  logic          chk_valid,
  input  logic          chk_mem,
  input  logic [2:0]    rs1_type,
  input  logic [IW-1:0] rs1_idx,
  input  logic [IW-1:0] rs1p_idx,
  input  logic [2:0]    rs2_type,
  input  logic [IW-1:0] rs2_idx,
  input  logic [IW-1:0] cc_idx,
  input  logic [2:0]    rd_type,
  input  logic [IW-1:0] rd_idx,
  output logic          held_valid,
  output logic [4:0]    pend,
  output logic          true_dep,
  output logic          addr_dep,
  output logic          issue_rdy,
  output logic          addr_rdy
);
  localparam logic [2:0] T_INT = 3'd0, T_I64 = 3'd1, T_FP = 3'd2, T_FPH = 3'd3, T_PAIR = 3'd4;
  localparam int NOP = 5;

  logic [NREG-1:0] int_busy_q, fp_busy_q;
  logic [NREG-1:0] int_wvec, fp_wvec, int_eff, fp_eff;

  assign int_wvec = int_wake_en ? (NREG'(1) << int_wake_idx) : '0;
  assign fp_wvec  = fp_wake_en  ? (NREG'(1) << fp_wake_idx)  : '0;
  assign int_eff  = int_busy_q & ~int_wvec;
  assign fp_eff   = fp_busy_q  & ~fp_wvec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_busy_q <= '0;
      fp_busy_q  <= '0;
    end else begin
      int_busy_q <= (int_busy_q & ~int_wvec) | (int_set_en ? (NREG'(1) << int_set_idx) : '0);
      fp_busy_q  <= (fp_busy_q  & ~fp_wvec)  | (fp_set_en  ? (NREG'(1) << fp_set_idx)  : '0);
    end
  end

  logic [IW-1:0] n_idx [NOP];
  logic [NOP-1:0] n_fp, n_use, n_pend;

  always_comb begin
    n_idx[0] = rs1_idx;  n_fp[0] = (rs1_type == T_FP) || (rs1_type == T_FPH);
    n_use[0] = rs1_type <= T_PAIR;
    n_idx[1] = rs1p_idx; n_fp[1] = 1'b0; n_use[1] = rs1_type == T_PAIR;
    n_idx[2] = rs2_idx;  n_fp[2] = (rs2_type == T_FP) || (rs2_type == T_FPH);
    n_use[2] = rs2_type <= T_FPH;
    n_idx[3] = cc_idx;   n_fp[3] = 1'b0; n_use[3] = 1'b1;
    n_idx[4] = rd_idx;   n_fp[4] = 1'b1; n_use[4] = rd_type == T_FPH;
    for (int k = 0; k < NOP; k++)
      n_pend[k] = n_use[k] && (n_fp[k] ? fp_eff[n_idx[k]] : int_eff[n_idx[k]]);
  end

  logic [IW-1:0] q_idx [NOP];
  logic [NOP-1:0] q_fp, pend_q, hit;
  logic valid_q, mem_q;

  always_comb
    for (int k = 0; k < NOP; k++)
      hit[k] = q_fp[k] ? fp_wvec[q_idx[k]] : int_wvec[q_idx[k]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      mem_q   <= 1'b0;
      pend_q  <= '0;
      q_fp    <= '0;
      for (int k = 0; k < NOP; k++) q_idx[k] <= '0;
    end else if (chk_valid) begin
      valid_q <= 1'b1;
      mem_q   <= chk_mem;
      pend_q  <= n_pend;
      q_fp    <= n_fp;
      for (int k = 0; k < NOP; k++) q_idx[k] <= n_idx[k];
    end else begin
      pend_q <= pend_q & ~hit;
    end
  end

  assign held_valid = valid_q;
  assign pend       = pend_q;
  assign true_dep   = |pend_q;
  assign addr_dep   = pend_q[2] | pend_q[3];
  assign issue_rdy  = valid_q & ~true_dep;
  assign addr_rdy   = valid_q & mem_q & ~addr_dep;

  p_addr_in_true_r6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_dep |-> true_dep);
  p_rsd_only_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && rd_type != T_FPH |=> !pend[4]);
  p_pair_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && rs1_type != T_PAIR |=> !pend[1]);
  p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && int_wake_en && rs1_type == T_INT && int_wake_idx == rs1_idx |=> !pend[0]);
  p_set_visible_r9: assert property (@(posedge clk) disable iff (!rst_n)
    int_set_en |=> int_busy_q[$past(int_set_idx)]);
  p_mask_shrinks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> (pend & ~$past(pend)) == '0);
  p_cc_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid && int_wake_en && int_wake_idx == q_idx[3] |=> !pend[3]);
endmodule

// File: tb/tb_opnd_scoreboard.sv
module tb_opnd_scoreboard;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic int_set_en, fp_set_en, int_wake_en, fp_wake_en, chk_valid, chk_mem;
  logic [5:0] int_set_idx, fp_set_idx, int_wake_idx, fp_wake_idx;
  logic [2:0] rs1_type, rs2_type, rd_type;
  logic [5:0] rs1_idx, rs1p_idx, rs2_idx, cc_idx, rd_idx;
  logic held_valid, true_dep, addr_dep, issue_rdy, addr_rdy;
  logic [4:0] pend;
  int checks = 0, errors = 0;

  opnd_scoreboard dut (.*);

  task automatic expect_out(string tag, logic [4:0] ep, logic et, logic ea, logic er, logic ear, logic ev);
    checks++;
    if ({pend, true_dep, addr_dep, issue_rdy, addr_rdy, held_valid} !== {ep, et, ea, er, ear, ev}) begin
      errors++;
      $display("FAIL %s: pend=%b t=%b a=%b rdy=%b ardy=%b v=%b expected pend=%b t=%b a=%b rdy=%b ardy=%b v=%b",
               tag, pend, true_dep, addr_dep, issue_rdy, addr_rdy, held_valid, ep, et, ea, er, ear, ev);
    end
  endtask

  task automatic iset(int i);
    int_set_en = 1; int_set_idx = 6'(i); @(negedge clk); int_set_en = 0;
  endtask
  task automatic fset(int i);
    fp_set_en = 1; fp_set_idx = 6'(i); @(negedge clk); fp_set_en = 0;
  endtask
  task automatic iwake(int i);
    int_wake_en = 1; int_wake_idx = 6'(i); @(negedge clk); int_wake_en = 0;
  endtask
  task automatic fwake(int i);
    fp_wake_en = 1; fp_wake_idx = 6'(i); @(negedge clk); fp_wake_en = 0;
  endtask
  task automatic issue(logic [2:0] t1, int i1, int i1p, logic [2:0] t2, int i2, int icc,
                       logic [2:0] td, int id, logic m);
    chk_valid = 1; chk_mem = m;
    rs1_type = t1; rs1_idx = 6'(i1); rs1p_idx = 6'(i1p);
    rs2_type = t2; rs2_idx = 6'(i2); cc_idx = 6'(icc);
    rd_type = td; rd_idx = 6'(id);
    @(negedge clk);
    chk_valid = 0;
  endtask

  task automatic t_reset;
    expect_out("R1 reset", 5'b0, 0, 0, 0, 0, 0);
  endtask
  task automatic t_route;
    iset(5);
    issue(0, 5, 0, 7, 0, 63, 7, 0, 0); expect_out("R2 int rs1 busy", 5'b00001, 1, 0, 0, 0, 1);
    issue(2, 5, 0, 7, 0, 63, 7, 0, 0); expect_out("R2 fp rs1 other table", 5'b0, 0, 0, 1, 0, 1);
    issue(1, 5, 0, 7, 0, 63, 7, 0, 0); expect_out("R2 int64 rs1", 5'b00001, 1, 0, 0, 0, 1);
    issue(7, 5, 0, 4, 5, 63, 7, 0, 0); expect_out("R2 rs2 code4 none", 5'b0, 0, 0, 1, 0, 1);
  endtask
  task automatic t_pair;
    iset(7);
    issue(4, 5, 7, 7, 0, 63, 7, 0, 0); expect_out("R3 pair both busy", 5'b00011, 1, 0, 0, 0, 1);
    issue(4, 8, 7, 7, 0, 63, 7, 0, 0); expect_out("R3 pair second only", 5'b00010, 1, 0, 0, 0, 1);
  endtask
  task automatic t_cc;
    issue(7, 0, 0, 1, 5, 7, 7, 0, 1); expect_out("R4 rs2 and cc busy", 5'b01100, 1, 1, 0, 0, 1);
  endtask
  task automatic t_rd;
    fset(9);
    issue(7, 0, 0, 7, 0, 63, 3, 9, 0); expect_out("R5 rd half busy", 5'b10000, 1, 0, 0, 0, 1);
    issue(7, 0, 0, 7, 0, 63, 2, 9, 0); expect_out("R5 rd full fp", 5'b0, 0, 0, 1, 0, 1);
  endtask
  task automatic t_wake;
    fset(5);
    issue(4, 5, 7, 2, 5, 63, 7, 0, 0); expect_out("R7 setup", 5'b00111, 1, 1, 0, 0, 1);
    fwake(5); expect_out("R7 fp wake keeps int bits", 5'b00011, 1, 0, 0, 0, 1);
    iwake(7); expect_out("R7 int wake pair reg", 5'b00001, 1, 0, 0, 0, 1);
    iwake(5); expect_out("R6 all cleared ready", 5'b0, 0, 0, 1, 0, 1);
  endtask
  task automatic t_bypass;
    iset(10);
    int_wake_en = 1; int_wake_idx = 10;
    issue(0, 10, 0, 7, 0, 63, 7, 0, 0);
    int_wake_en = 0;
    expect_out("R8 same-cycle wake", 5'b0, 0, 0, 1, 0, 1);
    issue(0, 10, 0, 7, 0, 63, 7, 0, 0); expect_out("R9 wake freed busy", 5'b0, 0, 0, 1, 0, 1);
  endtask
  task automatic t_setwin;
    int_set_en = 1; int_set_idx = 11; int_wake_en = 1; int_wake_idx = 11;
    @(negedge clk);
    int_set_en = 0; int_wake_en = 0;
    issue(0, 11, 0, 7, 0, 63, 7, 0, 0); expect_out("R9 set beats wake", 5'b00001, 1, 0, 0, 0, 1);
    int_set_en = 1; int_set_idx = 12;
    issue(0, 12, 0, 7, 0, 63, 7, 0, 0);
    int_set_en = 0;
    expect_out("R9 set not yet visible", 5'b0, 0, 0, 1, 0, 1);
    issue(0, 12, 0, 7, 0, 63, 7, 0, 0); expect_out("R9 set visible next", 5'b00001, 1, 0, 0, 0, 1);
  endtask
  task automatic t_mem;
    issue(0, 11, 0, 7, 0, 63, 7, 0, 1); expect_out("R10 mem rs1 only", 5'b00001, 1, 0, 0, 1, 1);
    issue(7, 0, 0, 0, 11, 63, 7, 0, 1); expect_out("R10 mem rs2 busy", 5'b00100, 1, 1, 0, 0, 1);
    iwake(11); expect_out("R10 mem addr freed", 5'b0, 0, 0, 1, 1, 1);
    issue(0, 12, 0, 7, 0, 63, 7, 0, 0); expect_out("R10 non-mem", 5'b00001, 1, 0, 0, 0, 1);
  endtask
  task automatic t_replace;
    issue(7, 0, 0, 7, 0, 63, 7, 0, 0); expect_out("R11 replaced by clean", 5'b0, 0, 0, 1, 0, 1);
    issue(0, 12, 0, 7, 0, 12, 7, 0, 0); expect_out("R11 replaced by busy", 5'b01001, 1, 1, 0, 0, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0;
    {int_set_en, fp_set_en, int_wake_en, fp_wake_en, chk_valid, chk_mem} = '0;
    {int_set_idx, fp_set_idx, int_wake_idx, fp_wake_idx} = '0;
    rs1_type = 7; rs2_type = 7; rd_type = 7;
    {rs1_idx, rs1p_idx, rs2_idx, cc_idx, rd_idx} = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_route;
    t_pair;
    t_cc;
    t_rd;
    t_wake;
    t_bypass;
    t_setwin;
    t_mem;
    t_replace;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule